// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block is a real-time clock peripheral reached through a simple memory-mapped register port. A 32-bit seconds counter advances by one on each clock cycle where the tick-enable input is high. That input stands in for a prescaled one-hertz strobe made elsewhere. Software can preload the counter and can program a match value. When the counter reaches the match value, a sticky alarm status bit is set. A single mask bit gates that status onto a level interrupt output.

The register port takes single-cycle write and read strobes with byte offsets. Read data comes back from a register one cycle after the strobe. A read of an offset that may not be read returns zero and raises a one-cycle error flag together with that data. The clock is always running, so the control register always reads back as one. The top of the address space holds an eight-byte identification window, with one byte returned per 32-bit word.

Top module: `rtc_match_timer`

## Requirements
- R1: After reset the counter, match value, load value, mask and alarm status are all zero, `irq` is 0, `bus_rdata` is 0 and `acc_err` is 0.
- R2: Each cycle with `tick_en` high increments the counter by one. A write to offset 0x08 sets the counter to the written value at that write's clock edge and takes priority over a tick. A read of 0x00 returns the counter. A read of 0x08 returns the last value written there.
- R3: The counter wraps from 0xFFFFFFFF to 0 on a tick.
- R4: The alarm status sets on the clock edge at which the counter becomes equal to the match value (written at 0x04, read back there). A match value below the current count fires only after the counter wraps.
- R5: A write to the match or load register that leaves the counter equal to the match value sets the alarm status at that write's edge, with no tick needed.
- R6: The alarm status stays set until a write to 0x1C. Any written data clears it, at that write's edge. When a match event falls in the same cycle as a clear, the status stays set.
- R7: A write to 0x10 keeps only bit 0 of the data as the mask, and a read of 0x10 returns it. `irq` is high exactly when status and mask are both 1, from the edge at which either one changes. A read of 0x14 returns the raw status. A read of 0x18 returns status AND mask.
- R8: A read of 0x0C returns 1. Writes to 0x0C have no effect, and the counter keeps running.
- R9: A read of an offset from 0xFE0 to 0xFFF returns, in bits 7:0, byte number (offset-0xFE0)>>2 of the sequence 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, with zero above. `acc_err` stays low for these reads.
- R10: A read of 0x1C, or of any offset that is not mapped, returns 0 and sets `acc_err` to 1. A read of a mapped readable offset leaves `acc_err` at 0.
- R11: `bus_rdata` and `acc_err` take their new values at the clock edge that samples `bus_rd`. `acc_err` lasts one cycle, and `bus_rdata` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable, one count per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| acc_err | output | 1 | One-cycle flag for a read of a non-readable offset |
| irq | output | 1 | Level interrupt, alarm status AND mask |

## Verification
Writes and ticks act at the clock edge that samples them, so the counter, the status, the mask and `irq` already hold their new values half a cycle later. The bench samples them at the falling edge that ends each access. Read data and the error flag are registered once, so each read task drives its strobe at one falling edge and samples at the next one, after exactly one rising edge. Same-cycle cases, such as a clear that coincides with a match tick, drive both inputs within one cycle so that their order is exact.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_COUNT = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_MATCH = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_LOAD  = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_MSKD  = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h01C;

    // Identification window: top 32 bytes of the offset space
    localparam logic [6:0] ID_WIN_TAG = 7'h7F;

    typedef struct packed {
        logic load;
        logic match;
        logic mask;
        logic clear;
    } wr_strobe_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h31;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic [CNT_W-1:0] load_reg
);

    always_comb begin
        if (load_wr)
            cnt_nxt = load_val;
        else if (tick_en)
            cnt_nxt = cnt + CNT_W'(1);
        else
            cnt_nxt = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            load_reg <= '0;
        end else begin
            cnt <= cnt_nxt;
            if (load_wr)
                load_reg <= load_val;
        end
    end

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  rtc_pkg::wr_strobe_t wr_s,
    input  logic [CNT_W-1:0]  wval,
    input  logic              mask_bit,
    input  logic [CNT_W-1:0]  cnt_nxt,
    output logic [CNT_W-1:0]  match,
    output logic              mask,
    output logic              ris,
    output logic              evt
);

    logic [CNT_W-1:0] match_nxt;
    logic             recheck;

    // Distance (match - count) reaching zero, in modular arithmetic
    assign match_nxt = wr_s.match ? wval : match;
    assign recheck   = tick_en | wr_s.load | wr_s.match;
    assign evt       = recheck && ((match_nxt - cnt_nxt) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            match <= '0;
            mask  <= 1'b0;
            ris   <= 1'b0;
        end else begin
            match <= match_nxt;
            if (wr_s.mask)
                mask <= mask_bit;
            if (evt)
                ris <= 1'b1;
            else if (wr_s.clear)
                ris <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = rtc_pkg::ADDR_W,
    parameter int DATA_W = rtc_pkg::DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [CNT_W-1:0]    cnt,
    input  logic [CNT_W-1:0]    match,
    input  logic [CNT_W-1:0]    load_reg,
    input  logic                mask,
    input  logic                ris,
    output rtc_pkg::wr_strobe_t wr_s,
    output logic [DATA_W-1:0]   rdata,
    output logic                err
);
    import rtc_pkg::*;

    logic [DATA_W-1:0] rd_val;
    logic              rd_bad;

    always_comb begin
        wr_s.load  = bus_wr && (bus_addr == OFF_LOAD);
        wr_s.match = bus_wr && (bus_addr == OFF_MATCH);
        wr_s.mask  = bus_wr && (bus_addr == OFF_MASK);
        wr_s.clear = bus_wr && (bus_addr == OFF_CLR);
    end

    always_comb begin
        rd_val = '0;
        rd_bad = 1'b0;
        if (bus_addr[ADDR_W-1:5] == ID_WIN_TAG) begin
            rd_val = DATA_W'(id_byte(bus_addr[4:2]));
        end else begin
            case (bus_addr)
                OFF_COUNT: rd_val = DATA_W'(cnt);
                OFF_MATCH: rd_val = DATA_W'(match);
                OFF_LOAD:  rd_val = DATA_W'(load_reg);
                OFF_CTRL:  rd_val = DATA_W'(1);
                OFF_MASK:  rd_val = DATA_W'(mask);
                OFF_RAW:   rd_val = DATA_W'(ris);
                OFF_MSKD:  rd_val = DATA_W'(ris & mask);
                default:   rd_bad = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            err <= bus_rd && rd_bad;
            if (bus_rd)
                rdata <= rd_val;
        end
    end

endmodule

// File: rtl/rtc_match_timer.sv
module rtc_match_timer #(
    parameter int CNT_W = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           tick_en,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [rtc_pkg::ADDR_W-1:0]     bus_addr,
    input  logic [rtc_pkg::DATA_W-1:0]     bus_wdata,
    output logic [rtc_pkg::DATA_W-1:0]     bus_rdata,
    output logic                           acc_err,
    output logic                           irq
);

    rtc_pkg::wr_strobe_t wr_s;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] load_reg;
    logic [CNT_W-1:0] match;
    logic             mask;
    logic             ris;
    logic             evt;

    rtc_bus_decode #(.CNT_W(CNT_W)) u_dec (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .cnt(cnt), .match(match), .load_reg(load_reg),
        .mask(mask), .ris(ris), .wr_s(wr_s), .rdata(bus_rdata), .err(acc_err)
    );

    rtc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick_en(tick_en), .load_wr(wr_s.load),
        .load_val(bus_wdata[CNT_W-1:0]), .cnt(cnt), .cnt_nxt(cnt_nxt),
        .load_reg(load_reg)
    );

    rtc_alarm #(.CNT_W(CNT_W)) u_alm (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_s(wr_s),
        .wval(bus_wdata[CNT_W-1:0]), .mask_bit(bus_wdata[0]),
        .cnt_nxt(cnt_nxt), .match(match), .mask(mask), .ris(ris), .evt(evt)
    );

    assign irq = ris & mask;

endmodule

// File: rtl/rtc_match_timer_chk.sv
module rtc_match_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       tick_en,
    input logic                       bus_rd,
    input logic [rtc_pkg::ADDR_W-1:0] bus_addr,
    input logic [rtc_pkg::DATA_W-1:0] bus_wdata,
    input logic [rtc_pkg::DATA_W-1:0] bus_rdata,
    input logic                       acc_err,
    input logic                       irq,
    input rtc_pkg::wr_strobe_t        wr_s,
    input logic [CNT_W-1:0]           cnt,
    input logic                       ris,
    input logic                       mask,
    input logic                       evt
);
    import rtc_pkg::*;

    AST_LOAD_SETS_COUNT: assert property (@(posedge clk) disable iff (rst)
        wr_s.load |=> cnt == $past(bus_wdata[CNT_W-1:0])); // R2

    AST_TICK_STEPS_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_s.load) |=> cnt == $past(cnt) + CNT_W'(1)); // R3

    AST_EVENT_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        evt |=> ris); // R4

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ris && !wr_s.clear) |=> ris); // R6

    AST_CLEAR_DROPS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (wr_s.clear && !evt) |=> !ris); // R6

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        !mask |-> !irq); // R7

    AST_CTRL_READS_ONE: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_CTRL) |=> (bus_rdata == 32'd1 && !acc_err)); // R8

    AST_CLR_READ_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_CLR) |=> (acc_err && bus_rdata == '0)); // R10

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !acc_err); // R11

endmodule

bind rtc_match_timer rtc_match_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .acc_err(acc_err), .irq(irq), .wr_s(wr_s), .cnt(cnt), .ris(ris),
    .mask(mask), .evt(evt)
);

// File: tb/test_rtc_match_timer.sv
module test_rtc_match_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        acc_err;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rd_data;
    logic        rd_err;

    always #2 clk = ~clk;

    rtc_match_timer i_rtc_match_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .acc_err(acc_err), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        rd_data = bus_rdata; rd_err = acc_err;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 err", 32'(acc_err), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(12'h000); chk("R1 count", rd_data, 0);
        rd(12'h004); chk("R1 match", rd_data, 0);
        rd(12'h008); chk("R1 load", rd_data, 0);
        rd(12'h010); chk("R1 mask", rd_data, 0);
        rd(12'h014); chk("R1 status", rd_data, 0);
    endtask

    task automatic t_count;
        wr(12'h008, 100, 1'b0);
        rd(12'h000); chk("R2 load sets count", rd_data, 100);
        rd(12'h008); chk("R2 load readback", rd_data, 100);
        ticks(5);
        rd(12'h000); chk("R2 five ticks", rd_data, 105);
        wr(12'h008, 40, 1'b1);
        rd(12'h000); chk("R2 load beats tick", rd_data, 40);
    endtask

    task automatic t_wrap;
        wr(12'h004, 32'h1234, 1'b0);
        wr(12'h008, 32'hFFFF_FFFF, 1'b0);
        ticks(1);
        rd(12'h000); chk("R3 wrap to zero", rd_data, 0);
        rd(12'h014); chk("R3 no alarm on wrap", rd_data, 0);
    endtask

    task automatic t_match;
        wr(12'h008, 10, 1'b0);
        wr(12'h004, 13, 1'b0);
        rd(12'h004); chk("R4 match readback", rd_data, 13);
        ticks(2);
        rd(12'h014); chk("R4 not yet", rd_data, 0);
        ticks(1);
        rd(12'h014); chk("R4 fires at equal", rd_data, 1);
        wr(12'h1C, 0, 1'b0);
        wr(12'h008, 32'hFFFF_FFFE, 1'b0);
        wr(12'h004, 1, 1'b0);
        ticks(2);
        rd(12'h014); chk("R4 below count waits", rd_data, 0);
        ticks(1);
        rd(12'h014); chk("R4 fires after wrap", rd_data, 1);
    endtask

    task automatic t_immediate;
        wr(12'h1C, 0, 1'b0);
        rd(12'h014); chk("R6 clear with equal count", rd_data, 0);
        wr(12'h008, 500, 1'b0);
        wr(12'h004, 500, 1'b0);
        rd(12'h014); chk("R5 match write equal", rd_data, 1);
        wr(12'h1C, 0, 1'b0);
        wr(12'h004, 777, 1'b0);
        rd(12'h014); chk("R5 cleared before load", rd_data, 0);
        wr(12'h008, 777, 1'b0);
        rd(12'h014); chk("R5 load write equal", rd_data, 1);
    endtask

    task automatic t_clear;
        wr(12'h1C, 0, 1'b0);
        wr(12'h004, 780, 1'b0);
        ticks(3);
        ticks(2);
        rd(12'h014); chk("R6 sticky after match", rd_data, 1);
        wr(12'h1C, 0, 1'b0);
        rd(12'h014); chk("R6 clear with zero data", rd_data, 0);
        wr(12'h008, 10, 1'b0);
        wr(12'h004, 11, 1'b0);
        wr(12'h1C, 0, 1'b1);
        rd(12'h014); chk("R6 event beats clear", rd_data, 1);
        wr(12'h1C, 32'hFFFF_FFFF, 1'b0);
        rd(12'h014); chk("R6 clear with ones", rd_data, 0);
    endtask

    task automatic t_mask;
        wr(12'h004, 11, 1'b0);
        wr(12'h010, 32'hFFFF_FFFE, 1'b0);
        chk("R7 irq masked", 32'(irq), 0);
        rd(12'h010); chk("R7 mask keeps bit0", rd_data, 0);
        rd(12'h018); chk("R7 masked status off", rd_data, 0);
        rd(12'h014); chk("R7 raw status on", rd_data, 1);
        wr(12'h010, 3, 1'b0);
        chk("R7 irq on mask edge", 32'(irq), 1);
        rd(12'h010); chk("R7 mask readback", rd_data, 1);
        rd(12'h018); chk("R7 masked status on", rd_data, 1);
        wr(12'h1C, 5, 1'b0);
        chk("R7 irq drops on clear", 32'(irq), 0);
        rd(12'h018); chk("R7 masked after clear", rd_data, 0);
    endtask

    task automatic t_ctrl;
        wr(12'h00C, 0, 1'b0);
        rd(12'h00C); chk("R8 control reads one", rd_data, 1);
        rd(12'h000); chk("R8 count before tick", rd_data, 11);
        ticks(1);
        rd(12'h000); chk("R8 still counting", rd_data, 12);
    endtask

    task automatic t_id;
        logic [7:0] ids [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) begin
            rd(12'hFE0 + 12'(4 * i));
            chk("R9 id byte", rd_data, 32'(ids[i]));
            chk("R9 id no error", 32'(rd_err), 0);
        end
    endtask

    task automatic t_err;
        rd(12'h01C); chk("R10 clear read data", rd_data, 0);
        chk("R10 clear read err", 32'(rd_err), 1);
        @(negedge clk);
        chk("R11 err one cycle", 32'(acc_err), 0);
        rd(12'h014);
        chk("R10 good read no err", 32'(rd_err), 0);
        rd(12'h020); chk("R10 unmapped data", rd_data, 0);
        chk("R10 unmapped err", 32'(rd_err), 1);
        rd(12'hFDC); chk("R10 below id err", 32'(rd_err), 1);
        rd(12'hFE4);
        repeat (2) @(negedge clk);
        chk("R11 rdata held", bus_rdata, 32'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_count;
        t_wrap;
        t_match;
        t_immediate;
        t_clear;
        t_mask;
        t_ctrl;
        t_id;
        t_err;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule